// File: doc/BRIEF.md
# Accumulator Processor with Single Shared Register Bus

This block is a small accumulator machine that fetches and runs 16-bit instructions. In each instruction word the top four bits are the operation and the low twelve bits are a memory address. Every transfer between its registers travels over one internal data bus. Two 3-bit select codes control the bus in each cycle: one names the register that drives it and the other names the register that captures it. The registers are the accumulator, the program counter, the instruction register, the memory address register, the memory buffer register, an input register and an output register.

A hardwired sequencer runs each instruction through fetch, decode, operand access and execute. Memory is a synchronous, word-addressed array outside the block. The memory address register feeds the address pins directly. Read data is loaded straight into the memory buffer register, and write data is taken from it. The machine provides load, store, add, subtract, input, output, conditional skip, unconditional jump and halt. The two bus select codes, the program counter and the accumulator are brought out as outputs so that the transfers can be observed.

Top module: `acc_bus_cpu`

## Requirements
- R1: After reset, the program counter, accumulator, output register and every other register read zero, `halted` is low, and the sequencer is at the start of a fetch. In that first cycle it drives the program counter (code 2) onto the bus and loads the address register (code 1).
- R2: Instruction bits 15:12 are the operation and bits 11:0 are the address X. Fetch reads the word at the program counter into the instruction register and then adds one to the program counter. Operation 9 (jump) sets the program counter to X.
- R3: Operation 1 sets AC = M[X]. Operation 3 sets AC = AC + M[X]. Operation 4 sets AC = AC - M[X]. Both arithmetic results wrap modulo 2^16. The accumulator changes only in a cycle where it is the bus destination.
- R4: Operation 2 writes AC to M[X]. For exactly one cycle `mem_wr` is high, `mem_addr` is X and `mem_wdata` is AC.
- R5: Operation 5 copies `in_data` into AC through the input register. Operation 6 copies AC into the output register, which drives `out_data`, and leaves AC unchanged. `out_data` changes only when the output register is the bus destination.
- R6: Operation 8 is the only conditional branch. It tests instruction bits 11:10: 00 skips if AC is negative (bit 15 set), 01 skips if AC is zero, 10 skips if AC is positive, and 11 never skips. A skip adds one more to the program counter.
- R7: Operation 7 raises `halted` five cycles after its fetch began. From then on `halted` stays high, the program counter stays fixed, and the block makes no memory access and no bus transfer.
- R8: An instruction takes 5 cycles of fetch and decode, plus 3 for operations 1, 3 and 4, plus 2 for operation 2, and plus 1 for operations 5, 6 and 8. Operation 9 adds nothing. Each instruction begins with the PC-to-address-register transfer.
- R9: Operations 0 and 10 to 15 take 5 cycles and change nothing except the fetch increment of the program counter.
- R10: `mem_rd` and `mem_wr` are never high together. `mem_addr` always shows the address register, and it changes only after a cycle in which that register was the bus destination.
- R11: Bus codes are 0 none, 1 address register, 2 program counter, 3 buffer register, 4 accumulator, 5 input register, 6 output register and 7 instruction register. When the instruction register drives the bus it supplies only its address field. A store moves AC to the buffer register with source 4 and destination 3. A jump uses source 7 and destination 2. Source and destination are never the same nonzero register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory word address, taken from the address register |
| mem_rd | output | 1 | Read request; data is expected on `mem_rdata` in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, taken from the buffer register |
| mem_rdata | input | 16 | Registered read data from memory |
| in_data | input | 16 | Value captured by the input register |
| out_data | output | 16 | Output register contents |
| halted | output | 1 | High once a halt has executed |
| bus_src | output | 3 | Code of the register driving the bus |
| bus_dst | output | 3 | Code of the register loading from the bus |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |

## Verification
The bench builds the block with its default values: a 16-bit word, a 12-bit address, the AND-OR bus multiplexer and the shared add/subtract adder. These values put the sign bit at bit 15, so the negative, zero and positive skip cases and wrap-around on add and subtract can all be reached from short programs. The bench memory decodes only the low eight address bits, which is enough for programs that jump forward and skip over halts. Two programs run one after the other with a reset between them. The second starts with a negative input value, which tests the sign-based skip from a fresh reset.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int SEL_W = 3;
   localparam int NSRC  = 1 << SEL_W;
   localparam int OPC_W = 4;

   typedef enum logic [SEL_W-1:0] {
      BUS_NONE = 3'd0,
      BUS_MAR  = 3'd1,
      BUS_PC   = 3'd2,
      BUS_MBR  = 3'd3,
      BUS_AC   = 3'd4,
      BUS_INR  = 3'd5,
      BUS_OUTR = 3'd6,
      BUS_IR   = 3'd7
   } bus_id_e;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'd3;
   localparam logic [OPC_W-1:0] OPC_SUBT  = 4'd4;
   localparam logic [OPC_W-1:0] OPC_INPUT = 4'd5;
   localparam logic [OPC_W-1:0] OPC_OUT   = 4'd6;
   localparam logic [OPC_W-1:0] OPC_HALT  = 4'd7;
   localparam logic [OPC_W-1:0] OPC_SKIP  = 4'd8;
   localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd9;

   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_ADD  = 2'd1,
      ALU_SUB  = 2'd2
   } alu_op_e;

   typedef enum logic [3:0] {
      ST_F0, ST_F1, ST_F2, ST_F3, ST_DC,
      ST_RD, ST_MB, ST_EX,
      ST_ST0, ST_WR,
      ST_IN1, ST_OUT, ST_SK, ST_HLT
   } seq_st_e;

endpackage

// File: rtl/acc_cpu_bus.sv
module acc_cpu_bus
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int MUX_STYLE = 0
) (
   input  logic [SEL_W-1:0]             sel,
   input  logic [NSRC-1:0][DATA_W-1:0]  srcs,
   output logic [DATA_W-1:0]            bus
);

   if (MUX_STYLE == 0) begin : g_andor
      logic [NSRC-1:0][DATA_W-1:0] gated;
      for (genvar g = 0; g < NSRC; g++) begin : g_gate
         assign gated[g] = (sel == SEL_W'(g)) ? srcs[g] : '0;
      end
      always_comb begin
         bus = '0;
         for (int i = 0; i < NSRC; i++) begin
            bus = bus | gated[i];
         end
      end
   end else begin : g_index
      assign bus = srcs[sel];
   end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ALU_SHARED = 1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_op_e           op,
   output logic [DATA_W-1:0] y,
   output logic              a_neg,
   output logic              a_zero
);

   logic [DATA_W-1:0] arith;

   if (ALU_SHARED != 0) begin : g_shared
      logic              do_sub;
      logic [DATA_W-1:0] b_eff;
      assign do_sub = (op == ALU_SUB);
      assign b_eff  = do_sub ? ~b : b;
      assign arith  = a + b_eff + DATA_W'(do_sub);
   end else begin : g_split
      logic [DATA_W-1:0] sum_v;
      logic [DATA_W-1:0] dif_v;
      assign sum_v = a + b;
      assign dif_v = a - b;
      assign arith = (op == ALU_SUB) ? dif_v : sum_v;
   end

   assign y      = (op == ALU_PASS) ? b : arith;
   assign a_neg  = a[DATA_W-1];
   assign a_zero = (a == '0);

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   input  logic [1:0]       cond,
   input  logic             ac_neg,
   input  logic             ac_zero,
   output bus_id_e          src,
   output bus_id_e          dst,
   output alu_op_e          alu_op,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             mbr_ld_mem,
   output logic             pc_inc,
   output logic             inr_ld,
   output logic             halted
);

   seq_st_e state_q, state_d;
   logic    take_skip;

   always_comb begin
      unique case (cond)
         2'b00:   take_skip = ac_neg;
         2'b01:   take_skip = ac_zero;
         2'b10:   take_skip = !ac_neg && !ac_zero;
         default: take_skip = 1'b0;
      endcase
   end

   always_comb begin
      state_d    = state_q;
      src        = BUS_NONE;
      dst        = BUS_NONE;
      alu_op     = ALU_PASS;
      mem_rd     = 1'b0;
      mem_wr     = 1'b0;
      mbr_ld_mem = 1'b0;
      pc_inc     = 1'b0;
      inr_ld     = 1'b0;
      halted     = 1'b0;
      unique case (state_q)
         ST_F0: begin
            src     = BUS_PC;
            dst     = BUS_MAR;
            state_d = ST_F1;
         end
         ST_F1: begin
            mem_rd  = 1'b1;
            state_d = ST_F2;
         end
         ST_F2: begin
            mbr_ld_mem = 1'b1;
            state_d    = ST_F3;
         end
         ST_F3: begin
            src     = BUS_MBR;
            dst     = BUS_IR;
            pc_inc  = 1'b1;
            state_d = ST_DC;
         end
         ST_DC: begin
            state_d = ST_F0;
            case (opcode)
               OPC_LOAD, OPC_ADD, OPC_SUBT: begin
                  src     = BUS_IR;
                  dst     = BUS_MAR;
                  state_d = ST_RD;
               end
               OPC_STORE: begin
                  src     = BUS_IR;
                  dst     = BUS_MAR;
                  state_d = ST_ST0;
               end
               OPC_INPUT: begin
                  inr_ld  = 1'b1;
                  state_d = ST_IN1;
               end
               OPC_OUT:  state_d = ST_OUT;
               OPC_HALT: state_d = ST_HLT;
               OPC_SKIP: state_d = ST_SK;
               OPC_JUMP: begin
                  src = BUS_IR;
                  dst = BUS_PC;
               end
               default: state_d = ST_F0;
            endcase
         end
         ST_RD: begin
            mem_rd  = 1'b1;
            state_d = ST_MB;
         end
         ST_MB: begin
            mbr_ld_mem = 1'b1;
            state_d    = ST_EX;
         end
         ST_EX: begin
            src     = BUS_MBR;
            dst     = BUS_AC;
            state_d = ST_F0;
            if (opcode == OPC_ADD) begin
               alu_op = ALU_ADD;
            end else if (opcode == OPC_SUBT) begin
               alu_op = ALU_SUB;
            end
         end
         ST_ST0: begin
            src     = BUS_AC;
            dst     = BUS_MBR;
            state_d = ST_WR;
         end
         ST_WR: begin
            mem_wr  = 1'b1;
            state_d = ST_F0;
         end
         ST_IN1: begin
            src     = BUS_INR;
            dst     = BUS_AC;
            state_d = ST_F0;
         end
         ST_OUT: begin
            src     = BUS_AC;
            dst     = BUS_OUTR;
            state_d = ST_F0;
         end
         ST_SK: begin
            pc_inc  = take_skip;
            state_d = ST_F0;
         end
         ST_HLT: begin
            halted  = 1'b1;
            state_d = ST_HLT;
         end
         default: state_d = ST_F0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_F0;
      end else begin
         state_q <= state_d;
      end
   end

endmodule

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 12,
   parameter int MUX_STYLE  = 0,
   parameter int ALU_SHARED = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] out_data,
   output logic              halted,
   output logic [SEL_W-1:0]  bus_src,
   output logic [SEL_W-1:0]  bus_dst,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] ac_o
);

   localparam int PAD_W = DATA_W - ADDR_W;

   if (DATA_W != OPC_W + ADDR_W) begin : g_bad_fmt
      $error("instruction word must be opcode plus address field");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("address field too narrow for the skip condition");
   end
   if (MUX_STYLE < 0 || MUX_STYLE > 1) begin : g_bad_mux
      $error("MUX_STYLE must be 0 or 1");
   end

   logic [ADDR_W-1:0] mar_q, pc_q;
   logic [DATA_W-1:0] mbr_q, ac_q, ir_q, inr_q, outr_q;

   bus_id_e src_sel, dst_sel;
   alu_op_e alu_op;
   logic    seq_rd, seq_wr, mbr_ld_mem, pc_inc, inr_ld, seq_halt;
   logic    ac_neg, ac_zero;

   logic [NSRC-1:0][DATA_W-1:0] srcs;
   logic [DATA_W-1:0]           bus_v;
   logic [DATA_W-1:0]           alu_y;

   always_comb begin
      srcs                 = '0;
      srcs[int'(BUS_MAR)]  = {{PAD_W{1'b0}}, mar_q};
      srcs[int'(BUS_PC)]   = {{PAD_W{1'b0}}, pc_q};
      srcs[int'(BUS_MBR)]  = mbr_q;
      srcs[int'(BUS_AC)]   = ac_q;
      srcs[int'(BUS_INR)]  = inr_q;
      srcs[int'(BUS_OUTR)] = outr_q;
      srcs[int'(BUS_IR)]   = {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]};
   end

   acc_cpu_bus #(
      .DATA_W    (DATA_W),
      .MUX_STYLE (MUX_STYLE)
   ) u_bus (
      .sel  (src_sel),
      .srcs (srcs),
      .bus  (bus_v)
   );

   acc_cpu_alu #(
      .DATA_W     (DATA_W),
      .ALU_SHARED (ALU_SHARED)
   ) u_alu (
      .a      (ac_q),
      .b      (bus_v),
      .op     (alu_op),
      .y      (alu_y),
      .a_neg  (ac_neg),
      .a_zero (ac_zero)
   );

   acc_cpu_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .opcode     (ir_q[DATA_W-1 -: OPC_W]),
      .cond       (ir_q[ADDR_W-1 -: 2]),
      .ac_neg     (ac_neg),
      .ac_zero    (ac_zero),
      .src        (src_sel),
      .dst        (dst_sel),
      .alu_op     (alu_op),
      .mem_rd     (seq_rd),
      .mem_wr     (seq_wr),
      .mbr_ld_mem (mbr_ld_mem),
      .pc_inc     (pc_inc),
      .inr_ld     (inr_ld),
      .halted     (seq_halt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar_q  <= '0;
         pc_q   <= '0;
         mbr_q  <= '0;
         ac_q   <= '0;
         ir_q   <= '0;
         inr_q  <= '0;
         outr_q <= '0;
      end else begin
         if (dst_sel == BUS_MAR) begin
            mar_q <= bus_v[ADDR_W-1:0];
         end
         if (dst_sel == BUS_PC) begin
            pc_q <= bus_v[ADDR_W-1:0];
         end else if (pc_inc) begin
            pc_q <= pc_q + 1'b1;
         end
         if (mbr_ld_mem) begin
            mbr_q <= mem_rdata;
         end else if (dst_sel == BUS_MBR) begin
            mbr_q <= bus_v;
         end
         if (dst_sel == BUS_AC) begin
            ac_q <= alu_y;
         end
         if (dst_sel == BUS_IR) begin
            ir_q <= bus_v;
         end
         if (inr_ld) begin
            inr_q <= in_data;
         end
         if (dst_sel == BUS_OUTR) begin
            outr_q <= bus_v;
         end
      end
   end

   assign mem_addr  = mar_q;
   assign mem_rd    = seq_rd;
   assign mem_wr    = seq_wr;
   assign mem_wdata = mbr_q;
   assign out_data  = outr_q;
   assign halted    = seq_halt;
   assign bus_src   = src_sel;
   assign bus_dst   = dst_sel;
   assign pc_o      = pc_q;
   assign ac_o      = ac_q;

endmodule

// File: rtl/acc_bus_cpu_chk.sv
module acc_bus_cpu_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              halted,
   input logic [2:0]        bus_src,
   input logic [2:0]        bus_dst,
   input logic [ADDR_W-1:0] pc_o,
   input logic [DATA_W-1:0] ac_o,
   input logic [DATA_W-1:0] out_data
);

   // R10
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R10
   mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_dst != 3'd1) |=> $stable(mem_addr));

   // R3
   ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_dst != 3'd4) |=> $stable(ac_o));

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_dst != 3'd6) |=> $stable(out_data));

   // R7
   halt_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc_o) && !mem_rd && !mem_wr));

   // R7
   halt_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (bus_src == 3'd0 && bus_dst == 3'd0));

   // R11
   no_self_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_src == bus_dst) |-> (bus_src == 3'd0));

endmodule

bind acc_bus_cpu acc_bus_cpu_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .halted   (halted),
   .bus_src  (bus_src),
   .bus_dst  (bus_dst),
   .pc_o     (pc_o),
   .ac_o     (ac_o),
   .out_data (out_data)
);

// File: tb/acc_bus_cpu_tb.sv
`timescale 1ns/1ps
module acc_bus_cpu_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic [15:0] in_data = '0;
   logic [15:0] out_data;
   logic        halted;
   logic [2:0]  bus_src, bus_dst;
   logic [11:0] pc_o;
   logic [15:0] ac_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [15:0] mem     [0:255];
   logic [15:0] ref_mem [0:255];

   always #2.5 clk = ~clk;

   acc_bus_cpu dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .in_data   (in_data),
      .out_data  (out_data),
      .halted    (halted),
      .bus_src   (bus_src),
      .bus_dst   (bus_dst),
      .pc_o      (pc_o),
      .ac_o      (ac_o)
   );

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000 && !done) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ins(input int op, input int a);
      return {op[3:0], a[11:0]};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         mem[i]     = 16'h0000;
         ref_mem[i] = 16'h0000;
      end
   endtask

   task automatic put(input int a, input logic [15:0] v);
      mem[a]     = v;
      ref_mem[a] = v;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: state right after release, first fetch cycle
      chk(pc_o == 12'h000, "R1 pc", 32'(pc_o), 0);
      chk(ac_o == 16'h0000, "R1 ac", 32'(ac_o), 0);
      chk(out_data == 16'h0000, "R1 out", 32'(out_data), 0);
      chk(halted == 1'b0, "R1 halted", 32'(halted), 0);
      chk(bus_src == 3'd2 && bus_dst == 3'd1, "R1 fetch bus codes",
          32'({bus_src, bus_dst}), 32'({3'd2, 3'd1}));
   endtask

   task automatic run_program(input logic [15:0] inval);
      logic [11:0] m_pc;
      logic [15:0] m_ac, m_out;
      int steps;
      bit stop;
      m_pc  = '0;
      m_ac  = '0;
      m_out = '0;
      steps = 0;
      stop  = 1'b0;
      in_data = inval;
      do_reset();
      while (!stop) begin
         logic [15:0] ir;
         logic [3:0]  op;
         logic [7:0]  x;
         logic [1:0]  cnd;
         int len;
         bit skip;
         // R8: every instruction begins with the PC to MAR transfer
         chk(bus_src == 3'd2 && bus_dst == 3'd1, "R8 fetch start",
             32'({bus_src, bus_dst}), 32'({3'd2, 3'd1}));
         chk(pc_o == m_pc, "R2 pc", 32'(pc_o), 32'(m_pc));
         chk(ac_o == m_ac, "R3 ac", 32'(ac_o), 32'(m_ac));
         chk(out_data == m_out, "R5 out", 32'(out_data), 32'(m_out));
         chk(halted == 1'b0, "R7 not halted", 32'(halted), 0);
         ir  = ref_mem[m_pc[7:0]];
         op  = ir[15:12];
         x   = ir[7:0];
         cnd = ir[11:10];
         m_pc = m_pc + 12'd1;
         len = 5;
         case (op)
            4'd1: begin m_ac = ref_mem[x]; len = 8; end
            4'd2: begin ref_mem[x] = m_ac; len = 7; end
            4'd3: begin m_ac = m_ac + ref_mem[x]; len = 8; end
            4'd4: begin m_ac = m_ac - ref_mem[x]; len = 8; end
            4'd5: begin m_ac = inval; len = 6; end
            4'd6: begin m_out = m_ac; len = 6; end
            4'd7: len = 5;
            4'd8: begin
               case (cnd)
                  2'b00:   skip = m_ac[15];
                  2'b01:   skip = (m_ac == 16'h0000);
                  2'b10:   skip = !m_ac[15] && (m_ac != 16'h0000);
                  default: skip = 1'b0;
               endcase
               if (skip) m_pc = m_pc + 12'd1;
               len = 6;
            end
            4'd9: m_pc = ir[11:0];
            default: len = 5; // R9: unused opcode
         endcase
         for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (op == 4'd7) begin
               chk(halted == (k == 5), "R7 halt timing", 32'(halted), 32'(k == 5));
            end else if (k < len) begin
               chk(mem_wr == (op == 4'd2 && k == 6), "R4 write strobe",
                   32'(mem_wr), 32'(op == 4'd2 && k == 6));
               chk(!(mem_rd && mem_wr), "R10 rd/wr exclusive",
                   32'({mem_rd, mem_wr}), 0);
            end
            if (op == 4'd2 && k == 5) begin
               chk(bus_src == 3'd4 && bus_dst == 3'd3, "R11 store bus codes",
                   32'({bus_src, bus_dst}), 32'({3'd4, 3'd3}));
            end
            if (op == 4'd2 && k == 6) begin
               chk(mem_addr == {4'h0, x}, "R4 store address", 32'(mem_addr), 32'(x));
               chk(mem_wdata == m_ac, "R4 store data", 32'(mem_wdata), 32'(m_ac));
               chk(mem_addr == {4'h0, x}, "R10 addr from MAR", 32'(mem_addr), 32'(x));
            end
            if (op == 4'd9 && k == 4) begin
               chk(bus_src == 3'd7 && bus_dst == 3'd2, "R11 jump bus codes",
                   32'({bus_src, bus_dst}), 32'({3'd7, 3'd2}));
            end
         end
         if (op == 4'd7) begin
            repeat (8) begin
               @(negedge clk);
               chk(halted == 1'b1, "R7 halted stays", 32'(halted), 1);
               chk(pc_o == m_pc, "R7 pc frozen", 32'(pc_o), 32'(m_pc));
               chk(!mem_rd && !mem_wr, "R7 no memory access",
                   32'({mem_rd, mem_wr}), 0);
            end
            chk(ac_o == m_ac, "R7 ac at halt", 32'(ac_o), 32'(m_ac));
            stop = 1'b1;
         end
         steps = steps + 1;
         if (steps > 100) begin
            chk(1'b0, "R8 program did not halt", 32'(steps), 100);
            stop = 1'b1;
         end
      end
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < 256; i++) begin
            if (mem[i] !== ref_mem[i]) bad = bad + 1;
         end
         chk(bad == 0, "R4 memory image", 32'(bad), 0);
      end
   endtask

   initial begin
      // Program 1: arithmetic, wrap, all skip codes, jump, unused opcodes
      clear_mem();
      put(0,  ins(1, 'h20));
      put(1,  ins(3, 'h21));
      put(2,  ins(4, 'h22));
      put(3,  ins(8, 'h000));   // R6 negative skip taken
      put(4,  ins(7, 0));
      put(5,  ins(2, 'h23));
      put(6,  ins(6, 0));
      put(7,  ins(5, 0));
      put(8,  ins(8, 'h400));   // R6 zero, not taken
      put(9,  ins(9, 'h00C));   // R2 jump
      put(10, ins(7, 0));
      put(11, ins(7, 0));
      put(12, ins(0, 0));       // R9
      put(13, ins(15, 'hFFF));  // R9
      put(14, ins(8, 'h800));   // R6 positive, taken
      put(15, ins(7, 0));
      put(16, ins(4, 'h24));
      put(17, ins(8, 'h400));   // R6 zero, taken
      put(18, ins(7, 0));
      put(19, ins(8, 'hC00));   // R6 never
      put(20, ins(6, 0));
      put(21, ins(1, 'h22));
      put(22, ins(3, 'h25));    // R3 wrap to zero
      put(23, ins(2, 'h26));
      put(24, ins(7, 0));
      put('h20, 16'h0005);
      put('h21, 16'h0003);
      put('h22, 16'h000A);
      put('h24, 16'h1234);
      put('h25, 16'hFFF6);
      put('h26, 16'h5555);
      run_program(16'h1234);

      // Program 2: negative input after a fresh reset
      clear_mem();
      put(0, ins(5, 0));
      put(1, ins(8, 'h000));
      put(2, ins(7, 0));
      put(3, ins(6, 0));
      put(4, ins(2, 'h30));
      put(5, ins(9, 7));
      put(6, ins(7, 0));
      put(7, ins(7, 0));
      run_program(16'h8000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule